// File: doc/BRIEF.md
# Program-Error Spare-Sector Replacement Sequencer

This block runs on the host side of a sector-oriented flash device. It is started once after every sector program. It polls the device status byte until the ready flag is set, then reads the failure flags. It either accepts the data, accepts it under error correction after an external ECC check, or moves the data to a spare sector. When it moves the data, it clears the device status and picks a free spare from a bitmap. It then writes the data again, in one of two ways: it can order the device to copy its internally held program data into the spare, or it can ask the host data path to reload the data from an external buffer and program it. The new sector is then judged in the same way. This repeats until a sector is accepted or no free spare is left.

Spares occupy a contiguous sector range. A spare that has been taken, or that has failed, is never offered again. The search keeps the chosen spare as far as possible from the sector that failed.

Top module: `spare_remap_seq`

## Requirements
- R1: While a polled status byte has bit 7 = 0 (busy), every other bit of that byte is ignored and polling continues with a new `stat_req`.
- R2: A status byte with bit 7 = 1, bit 4 = 0 (program check) and bit 5 = 0 (erase check) ends the run with a one-cycle `done`. In that case `final_sector` is the sector under test, bits 3..0 are don't-care, and no command byte is issued.
- R3: A ready status with bit 4 or bit 5 set and bit 6 = 0 leads straight to replacement. The next cycle issues command byte 50H (status clear), and no ECC check is requested.
- R4: A ready status with bit 4 or bit 5 set and bit 6 = 1 raises `ecc_req` until `ecc_done`. If `ecc_ok` = 1, the run ends with `done` and `ecc_used` = 1, and no replacement takes place.
- R5: If the ECC check reports `ecc_ok` = 0, the sector is replaced exactly as in R3: 50H first, then a spare is searched.
- R6: Spares are sectors SPARE_BASE to SPARE_BASE+NSPARE-1. The chosen spare is the free one with the largest absolute distance to the failed sector. On a tie, the lower sector number wins.
- R7: With `use_recovery` = 1 at start, a replacement issues four command bytes on consecutive cycles: 12H, the low address byte of the spare, the high address byte, then 40H. Polling resumes after that.
- R8: With `use_recovery` = 0, a replacement raises `reload_req` with `reload_sector` set to the spare until `reload_done`, issues no 12H, and then polls again.
- R9: A spare that has been chosen, or any pool sector that has failed, is never chosen again, across later runs as well. A failing spare triggers another replacement.
- R10: When no free spare remains, the run ends with `done` and `no_spare` = 1. `final_sector` then holds the last sector tried.
- R11: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also marks every spare free |
| start | input | 1 | Begin judging the sector just programmed |
| start_sector | input | SEC_W | Sector that was programmed |
| use_recovery | input | 1 | 1: device-internal recovery copy, 0: external reload |
| cmd_valid | output | 1 | A command or address byte is issued this cycle |
| cmd_data | output | 8 | Command or address byte |
| stat_req | output | 1 | Request a status byte read |
| stat_valid | input | 1 | Status byte present |
| stat_byte | input | 8 | Device status byte |
| ecc_req | output | 1 | Request readback and ECC check of the current sector |
| ecc_done | input | 1 | ECC check finished |
| ecc_ok | input | 1 | Data is correctable |
| reload_req | output | 1 | Request reload of buffered data into `reload_sector` |
| reload_sector | output | SEC_W | Target of the reload |
| reload_done | input | 1 | Reload and program issued |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle end-of-run pulse |
| no_spare | output | 1 | Last run ended with the spare pool exhausted |
| ecc_used | output | 1 | Last run accepted data under ECC correction |
| final_sector | output | SEC_W | Sector holding the data at the end of the last run |

## Verification
The hardest state to reach is the end of a chain: a spare that fails right after being chosen, while earlier runs have already used most of the pool, until the search comes back empty. The bench uses a small pool of six spares and keeps the bitmap state across directed runs. It feeds scripted status sequences with several failing bytes in a row, so that each run starts from a pool narrowed by the runs before it. A separate model of the pool in the bench predicts each pick.

// File: rtl/spare_remap_pkg.sv
package spare_remap_pkg;

  localparam logic [7:0] CMD_STAT_CLR = 8'h50;
  localparam logic [7:0] CMD_RECOVER  = 8'h12;
  localparam logic [7:0] CMD_EXECUTE  = 8'h40;

  localparam int ST_READY_BIT = 7;
  localparam int ST_ECC_BIT   = 6;
  localparam int ST_ERASE_BIT = 5;
  localparam int ST_PROG_BIT  = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_ECCW, S_CLR, S_SRCH, S_REC, S_RELD, S_FIN
  } seq_state_t;

  function automatic logic [31:0] sec_dist(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic in_pool(input logic [31:0] s, input logic [31:0] base,
                                   input logic [31:0] n);
    return (s >= base) && (s < base + n);
  endfunction

endpackage

// File: rtl/spare_remap_stat_dec.sv
module spare_remap_stat_dec
  import spare_remap_pkg::*;
(
  input  logic [7:0] stat_byte,
  output logic       st_ready,
  output logic       st_failed,
  output logic       st_ecc_hint
);
  always_comb begin
    st_ready    = stat_byte[ST_READY_BIT];
    st_failed   = st_ready & (stat_byte[ST_PROG_BIT] | stat_byte[ST_ERASE_BIT]);
    st_ecc_hint = stat_byte[ST_ECC_BIT];
  end
endmodule

// File: rtl/spare_remap_pool.sv
module spare_remap_pool
  import spare_remap_pkg::*;
#(
  parameter int SEC_W      = 14,
  parameter int NSPARE     = 290,
  parameter int SPARE_BASE = 16094
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_start,
  input  logic [SEC_W-1:0] ref_sector,
  input  logic             retire_valid,
  input  logic [SEC_W-1:0] retire_sector,
  output logic             srch_done,
  output logic             srch_found,
  output logic [SEC_W-1:0] srch_sector
);
  localparam int IDX_W = (NSPARE > 1) ? $clog2(NSPARE) : 1;
  localparam logic [SEC_W-1:0] BASE_S = SEC_W'(SPARE_BASE);

  logic [NSPARE-1:0] free_map;
  logic [IDX_W-1:0]  idx, best_idx, ret_idx;
  logic [31:0]       best_dist, cand_dist;
  logic [SEC_W-1:0]  cand_sector;
  logic              running, have, take, last, ret_hit;

  always_comb begin
    cand_sector = BASE_S + SEC_W'(idx);
    cand_dist   = sec_dist(32'(cand_sector), 32'(ref_sector));
    take        = running && free_map[idx] && (!have || cand_dist > best_dist);
    last        = (idx == IDX_W'(NSPARE - 1));
    ret_hit     = retire_valid && in_pool(32'(retire_sector), 32'(SPARE_BASE), 32'(NSPARE));
    ret_idx     = IDX_W'(retire_sector - BASE_S);
    srch_found  = have;
    srch_sector = BASE_S + SEC_W'(best_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map  <= '1;
      idx       <= '0;
      best_idx  <= '0;
      best_dist <= '0;
      running   <= 1'b0;
      have      <= 1'b0;
      srch_done <= 1'b0;
    end else begin
      srch_done <= 1'b0;
      if (ret_hit) free_map[ret_idx] <= 1'b0;
      if (srch_start) begin
        running <= 1'b1;
        idx     <= '0;
        have    <= 1'b0;
      end else if (running) begin
        if (take) begin
          have      <= 1'b1;
          best_idx  <= idx;
          best_dist <= cand_dist;
        end
        if (last) begin
          running   <= 1'b0;
          srch_done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spare_remap_seq.sv
module spare_remap_seq
  import spare_remap_pkg::*;
#(
  parameter int SEC_W      = 14,
  parameter int NSPARE     = 290,
  parameter int SPARE_BASE = 16094
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEC_W-1:0] start_sector,
  input  logic             use_recovery,
  output logic             cmd_valid,
  output logic [7:0]       cmd_data,
  output logic             stat_req,
  input  logic             stat_valid,
  input  logic [7:0]       stat_byte,
  output logic             ecc_req,
  input  logic             ecc_done,
  input  logic             ecc_ok,
  output logic             reload_req,
  output logic [SEC_W-1:0] reload_sector,
  input  logic             reload_done,
  output logic             busy,
  output logic             done,
  output logic             no_spare,
  output logic             ecc_used,
  output logic [SEC_W-1:0] final_sector
);
  seq_state_t       st;
  logic [SEC_W-1:0] cur;
  logic [1:0]       rec_cnt;
  logic             recov_mode;
  logic             st_ready, st_failed, st_ecc_hint;
  logic             srch_done, srch_found;
  logic [SEC_W-1:0] srch_sector;
  logic             retire_valid;
  logic [SEC_W-1:0] retire_sector;
  logic [15:0]      addr16;

  // Named internal events for the checker
  logic w_in_poll, w_judge, w_pick, w_exhaust;

  spare_remap_stat_dec u_dec (
    .stat_byte  (stat_byte),
    .st_ready   (st_ready),
    .st_failed  (st_failed),
    .st_ecc_hint(st_ecc_hint)
  );

  spare_remap_pool #(.SEC_W(SEC_W), .NSPARE(NSPARE), .SPARE_BASE(SPARE_BASE)) u_pool (
    .clk          (clk),
    .rst_n        (rst_n),
    .srch_start   (st == S_CLR),
    .ref_sector   (cur),
    .retire_valid (retire_valid),
    .retire_sector(retire_sector),
    .srch_done    (srch_done),
    .srch_found   (srch_found),
    .srch_sector  (srch_sector)
  );

  always_comb begin
    w_in_poll     = (st == S_POLL);
    w_judge       = w_in_poll && stat_valid && st_ready;
    w_pick        = (st == S_SRCH) && srch_done && srch_found;
    w_exhaust     = (st == S_SRCH) && srch_done && !srch_found;
    retire_valid  = (st == S_CLR) || w_pick;
    retire_sector = (st == S_CLR) ? cur : srch_sector;
    addr16        = 16'(cur);
    stat_req      = w_in_poll;
    ecc_req       = (st == S_ECCW);
    reload_req    = (st == S_RELD);
    reload_sector = cur;
    busy          = (st != S_IDLE);
    done          = (st == S_FIN);
    final_sector  = cur;
    cmd_valid     = (st == S_CLR) || (st == S_REC);
    unique case (rec_cnt)
      2'd0:    cmd_data = CMD_RECOVER;
      2'd1:    cmd_data = addr16[7:0];
      2'd2:    cmd_data = addr16[15:8];
      default: cmd_data = CMD_EXECUTE;
    endcase
    if (st == S_CLR) cmd_data = CMD_STAT_CLR;
    if (!cmd_valid)  cmd_data = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur        <= '0;
      rec_cnt    <= '0;
      recov_mode <= 1'b0;
      no_spare   <= 1'b0;
      ecc_used   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          cur        <= start_sector;
          recov_mode <= use_recovery;
          no_spare   <= 1'b0;
          ecc_used   <= 1'b0;
          st         <= S_POLL;
        end
        S_POLL: if (w_judge) begin
          if (!st_failed)      st <= S_FIN;
          else if (st_ecc_hint) st <= S_ECCW;
          else                 st <= S_CLR;
        end
        S_ECCW: if (ecc_done) begin
          if (ecc_ok) begin
            ecc_used <= 1'b1;
            st       <= S_FIN;
          end else begin
            st <= S_CLR;
          end
        end
        S_CLR: st <= S_SRCH;
        S_SRCH: if (w_exhaust) begin
          no_spare <= 1'b1;
          st       <= S_FIN;
        end else if (w_pick) begin
          cur     <= srch_sector;
          rec_cnt <= '0;
          st      <= recov_mode ? S_REC : S_RELD;
        end
        S_REC: begin
          rec_cnt <= rec_cnt + 1'b1;
          if (rec_cnt == 2'd3) st <= S_POLL;
        end
        S_RELD: if (reload_done) st <= S_POLL;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spare_remap_seq_chk.sv
module spare_remap_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       w_in_poll,
  input logic       stat_valid,
  input logic [7:0] stat_byte,
  input logic       cmd_valid,
  input logic [7:0] cmd_data,
  input logic       stat_req,
  input logic       ecc_req,
  input logic       reload_req,
  input logic       done,
  input logic       no_spare,
  input logic       busy,
  input logic       start
);
  p_busy_keeps_polling_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (w_in_poll && stat_valid && !stat_byte[7]) |=> w_in_poll);

  p_pass_ends_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_in_poll && stat_valid && stat_byte[7] && !stat_byte[4] && !stat_byte[5]) |=> done);

  p_direct_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_in_poll && stat_valid && stat_byte[7] && !stat_byte[6] && (stat_byte[4] || stat_byte[5]))
    |=> (cmd_valid && cmd_data == 8'h50));

  p_ecc_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_in_poll && stat_valid && stat_byte[7] && stat_byte[6] && (stat_byte[4] || stat_byte[5]))
    |=> ecc_req);

  p_recover_addr_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data == 8'h12) |=> cmd_valid);

  p_one_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_req, ecc_req, reload_req, cmd_valid}));

  p_exhaust_reported_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_spare) |-> done);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind spare_remap_seq spare_remap_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .w_in_poll (w_in_poll),
  .stat_valid(stat_valid),
  .stat_byte (stat_byte),
  .cmd_valid (cmd_valid),
  .cmd_data  (cmd_data),
  .stat_req  (stat_req),
  .ecc_req   (ecc_req),
  .reload_req(reload_req),
  .done      (done),
  .no_spare  (no_spare),
  .busy      (busy),
  .start     (start)
);

// File: tb/spare_remap_seq_bench.sv
module spare_remap_seq_bench;
  localparam int SEC_W = 8;
  localparam int NSP   = 6;
  localparam int BASE  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SEC_W-1:0] start_sector = '0;
  logic use_recovery = 1'b0;
  logic cmd_valid;
  logic [7:0] cmd_data;
  logic stat_req, ecc_req, reload_req;
  logic stat_valid = 1'b0;
  logic [7:0] stat_byte = 8'h00;
  logic ecc_done = 1'b0, ecc_ok = 1'b0;
  logic reload_done = 1'b0;
  logic [SEC_W-1:0] reload_sector, final_sector;
  logic busy, done, no_spare, ecc_used;

  always #10 clk = ~clk;

  spare_remap_seq #(.SEC_W(SEC_W), .NSPARE(NSP), .SPARE_BASE(BASE)) u_spare_remap_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sector(start_sector),
    .use_recovery(use_recovery), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .stat_req(stat_req), .stat_valid(stat_valid), .stat_byte(stat_byte),
    .ecc_req(ecc_req), .ecc_done(ecc_done), .ecc_ok(ecc_ok),
    .reload_req(reload_req), .reload_sector(reload_sector), .reload_done(reload_done),
    .busy(busy), .done(done), .no_spare(no_spare), .ecc_used(ecc_used),
    .final_sector(final_sector)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] stat_q [0:15];
  int stat_n = 1, stat_ptr = 0;
  logic ecc_ok_val = 1'b0;
  int ecc_cnt = 0, reload_cnt = 0;
  int reload_tgt = 0;
  logic [7:0] cmd_log [0:31];
  int cmd_n = 0;
  bit model_free [0:NSP-1];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Flash/host side responders, all on the falling edge
  always @(negedge clk) begin
    if (stat_req && !stat_valid) begin
      stat_valid = 1'b1;
      stat_byte  = stat_q[(stat_ptr < stat_n) ? stat_ptr : stat_n - 1];
      stat_ptr++;
    end else begin
      stat_valid = 1'b0;
    end
    if (ecc_req && !ecc_done) begin
      ecc_done = 1'b1; ecc_ok = ecc_ok_val; ecc_cnt++;
    end else begin
      ecc_done = 1'b0;
    end
    if (reload_req && !reload_done) begin
      reload_done = 1'b1; reload_tgt = int'(reload_sector); reload_cnt++;
    end else begin
      reload_done = 1'b0;
    end
    if (cmd_valid && cmd_n < 32) begin
      cmd_log[cmd_n] = cmd_data; cmd_n++;
    end
  end

  function automatic int pick(input int failed);
    int best = -1;
    int bd = -1;
    for (int i = 0; i < NSP; i++) begin
      int s = BASE + i;
      int d = (s > failed) ? s - failed : failed - s;
      if (model_free[i] && d > bd) begin best = s; bd = d; end
    end
    return best;
  endfunction

  task automatic retire(input int s);
    if (s >= BASE && s < BASE + NSP) model_free[s - BASE] = 1'b0;
  endtask

  task automatic prep(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input int n, input logic eok);
    stat_q[0] = b0; stat_q[1] = b1; stat_q[2] = b2; stat_q[3] = b3;
    stat_n = n; stat_ptr = 0; ecc_ok_val = eok;
    ecc_cnt = 0; reload_cnt = 0; cmd_n = 0; reload_tgt = -1;
  endtask

  task automatic run(input int sec, input logic recov);
    int t = 0;
    @(negedge clk);
    start_sector = SEC_W'(sec); use_recovery = recov; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
  endtask

  task automatic t_reset();
    chk("R2 reset busy", int'(busy), 0);
    chk("R2 reset done", int'(done), 0);
    chk("R8 reset no request", int'(stat_req | ecc_req | reload_req | cmd_valid), 0);
  endtask

  task automatic t_busy_then_pass();
    prep(8'h00, 8'h80, 8'h80, 8'h80, 2, 1'b0);
    run(10, 1'b0);
    chk("R1 polls until ready", stat_ptr, 2);
    chk("R2 final sector", int'(final_sector), 10);
    chk("R2 no command", cmd_n, 0);
    chk("R2 no ecc flag", int'(ecc_used), 0);
  endtask

  task automatic t_reserved_ignored();
    prep(8'h8F, 8'h8F, 8'h8F, 8'h8F, 1, 1'b0);
    run(11, 1'b0);
    chk("R2 low bits dont care", int'(final_sector), 11);
    chk("R2 no clear", cmd_n, 0);
  endtask

  task automatic t_busy_garbage();
    prep(8'h70, 8'h30, 8'h80, 8'h80, 3, 1'b0);
    run(12, 1'b0);
    chk("R1 fail bits ignored while busy", stat_ptr, 3);
    chk("R1 no replacement", cmd_n + ecc_cnt, 0);
  endtask

  task automatic t_ecc_accept();
    prep(8'hD0, 8'h80, 8'h80, 8'h80, 1, 1'b1);
    run(13, 1'b0);
    chk("R4 ecc asked", ecc_cnt, 1);
    chk("R4 ecc_used", int'(ecc_used), 1);
    chk("R4 kept sector", int'(final_sector), 13);
    chk("R4 no clear", cmd_n, 0);
  endtask

  task automatic t_direct_reload();
    int e;
    prep(8'h90, 8'h80, 8'h80, 8'h80, 2, 1'b0);
    e = pick(10); retire(e);
    run(10, 1'b0);
    chk("R3 no ecc on bit6=0", ecc_cnt, 0);
    chk("R3 clear byte", int'(cmd_log[0]), 8'h50);
    chk("R8 only clear issued", cmd_n, 1);
    chk("R6 farthest spare", reload_tgt, e);
    chk("R8 one reload", reload_cnt, 1);
    chk("R6 final", int'(final_sector), e);
  endtask

  task automatic t_ecc_reject_recover();
    int e;
    prep(8'hE0, 8'h80, 8'h80, 8'h80, 2, 1'b0);
    e = pick(10); retire(e);
    run(10, 1'b1);
    chk("R5 ecc asked", ecc_cnt, 1);
    chk("R5 clear byte", int'(cmd_log[0]), 8'h50);
    chk("R7 recover cmd", int'(cmd_log[1]), 8'h12);
    chk("R7 addr low", int'(cmd_log[2]), e & 255);
    chk("R7 addr high", int'(cmd_log[3]), e >> 8);
    chk("R7 execute", int'(cmd_log[4]), 8'h40);
    chk("R7 byte count", cmd_n, 5);
    chk("R7 no reload", reload_cnt, 0);
    chk("R5 ecc flag clear", int'(ecc_used), 0);
    chk("R9 final", int'(final_sector), e);
  endtask

  task automatic t_start_ignored();
    prep(8'h00, 8'h00, 8'h00, 8'h80, 4, 1'b0);
    @(negedge clk);
    start_sector = 8'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start_sector = 8'd30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 100 && !done; t++) @(negedge clk);
    chk("R11 first run kept", int'(final_sector), 20);
    chk("R11 poll count", stat_ptr, 4);
  endtask

  task automatic t_chain();
    int e1, e2;
    prep(8'h90, 8'h90, 8'h80, 8'h80, 3, 1'b0);
    e1 = pick(10); retire(e1);
    e2 = pick(e1); retire(e2);
    run(10, 1'b0);
    chk("R9 two reloads", reload_cnt, 2);
    chk("R9 second spare", int'(final_sector), e2);
    chk("R9 no exhaustion", int'(no_spare), 0);
  endtask

  task automatic t_exhaust();
    int e = 10, last = 10, reps = 0;
    prep(8'h90, 8'h90, 8'h90, 8'h90, 1, 1'b0);
    while (pick(e) >= 0) begin e = pick(e); retire(e); last = e; reps++; end
    run(10, 1'b1);
    chk("R10 no_spare", int'(no_spare), 1);
    chk("R10 last sector tried", int'(final_sector), last);
    chk("R10 clears issued", (reps == 0) ? cmd_n : int'(cmd_log[5]), (reps == 0) ? 1 : 8'h50);
  endtask

  initial begin
    for (int i = 0; i < NSP; i++) model_free[i] = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_busy_then_pass();
    t_reserved_ignored();
    t_busy_garbage();
    t_ecc_accept();
    t_direct_reload();
    t_ecc_reject_recover();
    t_start_ignored();
    t_chain();
    t_exhaust();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL global watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule